// File: doc/BRIEF.md
# Fewest-in-flight fetch thread selector

This block chooses, once per clock, which hardware thread of a simultaneous-multithreaded front end may fetch. For every thread it keeps a saturating count of instructions in flight. The count goes up by the number that entered decode that cycle. It goes down by the number that left through retire or squash in the same cycle. Fetch goes to the eligible thread with the smallest count. This gives priority to threads that drain quickly and keeps a clogged thread from taking over the front end.

Threads whose spin flag is raised are busy-waiting, so they fall into a lower class. They compete only when no eligible thread outside that class exists. When several threads share the lowest count, the winner is the first one found in rotation after the thread granted most recently. A per-thread flush sets that thread's count to zero. The grant is registered: the thread ID and valid bit seen after a clock edge are decided from the inputs and counts in place before that edge.

Top module: `icount_fetch_sel`

## Requirements
- R1: While reset is high, and on the first cycle after it, sel_valid is 0 and sel_tid is 0. All in-flight counts start at zero.
- R2: A thread whose fetch_en bit is 0 is never selected. When no fetch_en bit is set, sel_valid is 0 after the next edge.
- R3: The grant goes to the eligible thread whose in-flight count is smallest.
- R4: A thread with its spin_wait bit set is selected only when every eligible thread has spin_wait set. Within that spinning group, R3 and R5 still apply.
- R5: A tie on the smallest count goes to the first tied thread in the order last+1, last+2, and so on, modulo the thread count. Here "last" is the most recently granted thread, and it is taken as thread NUM_THREADS-1 after reset.
- R6: Each cycle a thread's count changes by enter minus leave. Thread i's fields are bits [3i+2:3i] of enter_cnt and leave_cnt, and each field holds a value from 0 to 4.
- R7: A count saturates: it never goes above 63 and never falls below 0.
- R8: A flush bit clears that thread's count to 0 at the next edge, overriding any enter or leave in the same cycle.
- R9: sel_valid and sel_tid are registered. They reflect the fetch_en, spin_wait and counts present before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_en | input | 4 | Per-thread fetch eligibility |
| spin_wait | input | 4 | Per-thread busy-wait flag (demotes the thread) |
| flush | input | 4 | Per-thread count clear |
| enter_cnt | input | 12 | Per-thread instructions entering decode, 3 bits each |
| leave_cnt | input | 12 | Per-thread instructions retired or squashed, 3 bits each |
| sel_valid | output | 1 | A thread is granted fetch |
| sel_tid | output | 2 | Granted thread ID |

## Verification
The bench builds the block with its default parameters: four threads, 6-bit counts and 3-bit step fields. With these values the 63 ceiling is reached in sixteen cycles of maximum entry, and every rotation start point can be visited in a short run. Directed sequences cover saturation against a thread one below the ceiling, the floor under a surplus of leaves, a flush coinciding with entries, and spinning groups of several sizes. A long pseudo-random phase follows, with every grant compared against a behavioural model of the counts.

// File: rtl/icount_pkg.sv
package icount_pkg;
  // class of a thread in the current selection
  typedef enum logic [1:0] {
    CLS_OFF    = 2'd0,
    CLS_ACTIVE = 2'd1,
    CLS_SPIN   = 2'd2
  } thr_class_e;
endpackage

// File: rtl/icount_counter.sv
module icount_counter #(
  parameter int CNT_W = 6,
  parameter int DW    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [DW-1:0]    inc,
  input  logic [DW-1:0]    dec,
  output logic [CNT_W-1:0] cnt
);
  localparam int EW = CNT_W + 2;
  localparam logic [EW-1:0] TOP = {2'b00, {CNT_W{1'b1}}};

  logic [EW-1:0] raised;
  logic [EW-1:0] lowered;
  logic [EW-1:0] drop;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    raised  = {2'b00, cnt} + EW'(inc);
    drop    = EW'(dec);
    lowered = raised - drop;
    if (clr)
      cnt_d = '0;
    else if (raised < drop)
      cnt_d = '0;
    else if (lowered > TOP)
      cnt_d = {CNT_W{1'b1}};
    else
      cnt_d = lowered[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt_d;
  end
endmodule

// File: rtl/icount_pick.sv
module icount_pick #(
  parameter int N     = 4,
  parameter int CNT_W = 6,
  parameter int TW    = 2
) (
  input  logic [N-1:0]            cand,
  input  logic [N-1:0][CNT_W-1:0] cnts,
  input  logic [TW-1:0]           last,
  output logic                    found,
  output logic [TW-1:0]           pick
);
  logic [CNT_W-1:0] best;

  always_comb begin
    found = 1'b0;
    best  = '0;
    pick  = '0;
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = int'(last) + k;
      if (idx >= N) idx = idx - N;
      if (cand[idx] && (!found || cnts[idx] < best)) begin
        found = 1'b1;
        best  = cnts[idx];
        pick  = TW'(idx);
      end
    end
  end
endmodule

// File: rtl/icount_fetch_sel.sv
module icount_fetch_sel #(
  parameter int NUM_THREADS = 4,
  parameter int CNT_W       = 6,
  parameter int DW          = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_THREADS-1:0]      fetch_en,
  input  logic [NUM_THREADS-1:0]      spin_wait,
  input  logic [NUM_THREADS-1:0]      flush,
  input  logic [NUM_THREADS*DW-1:0]   enter_cnt,
  input  logic [NUM_THREADS*DW-1:0]   leave_cnt,
  output logic                        sel_valid,
  output logic [$clog2(NUM_THREADS)-1:0] sel_tid
);
  import icount_pkg::*;

  localparam int N  = NUM_THREADS;
  localparam int TW = $clog2(NUM_THREADS);

  logic [N-1:0][CNT_W-1:0] cnts;
  logic [N*CNT_W-1:0]      cnt_flat;
  thr_class_e              cls [N];
  logic [N-1:0]            active_m;
  logic [N-1:0]            spin_m;
  logic [N-1:0]            cand;
  logic                    found;
  logic [TW-1:0]           pick;
  logic [TW-1:0]           last_q;

  for (genvar i = 0; i < N; i++) begin : g_thr
    icount_counter #(.CNT_W(CNT_W), .DW(DW)) u_cnt (
      .clk (clk),
      .rst (rst),
      .clr (flush[i]),
      .inc (enter_cnt[i*DW +: DW]),
      .dec (leave_cnt[i*DW +: DW]),
      .cnt (cnts[i])
    );
    assign cnt_flat[i*CNT_W +: CNT_W] = cnts[i];

    always_comb begin
      if (!fetch_en[i])    cls[i] = CLS_OFF;
      else if (spin_wait[i]) cls[i] = CLS_SPIN;
      else                 cls[i] = CLS_ACTIVE;
    end
    assign active_m[i] = (cls[i] == CLS_ACTIVE);
    assign spin_m[i]   = (cls[i] == CLS_SPIN);
  end

  // spinning threads compete only when no active thread exists
  assign cand = (|active_m) ? active_m : spin_m;

  icount_pick #(.N(N), .CNT_W(CNT_W), .TW(TW)) u_pick (
    .cand  (cand),
    .cnts  (cnts),
    .last  (last_q),
    .found (found),
    .pick  (pick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_valid <= 1'b0;
      sel_tid   <= '0;
      last_q    <= TW'(N - 1);
    end else begin
      sel_valid <= found;
      sel_tid   <= found ? pick : '0;
      if (found) last_q <= pick;
    end
  end
endmodule

// File: rtl/icount_fetch_sel_chk.sv
module icount_fetch_sel_chk #(
  parameter int N     = 4,
  parameter int CNT_W = 6,
  parameter int DW    = 3,
  parameter int TW    = 2
) (
  input logic                clk,
  input logic                rst,
  input logic [N-1:0]        fetch_en,
  input logic [N-1:0]        spin_wait,
  input logic [N-1:0]        flush,
  input logic [N*DW-1:0]     enter_cnt,
  input logic [N*DW-1:0]     leave_cnt,
  input logic                sel_valid,
  input logic [TW-1:0]       sel_tid,
  input logic [N*CNT_W-1:0]  cnt_flat
);
  logic [N-1:0] en_prev;
  logic [N-1:0] spin_prev;

  always_ff @(posedge clk) begin
    en_prev   <= fetch_en;
    spin_prev <= spin_wait;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> !sel_valid);

  // R2
  enabled_only_chk: assert property (@(posedge clk) disable iff (rst)
    sel_valid |-> en_prev[sel_tid]);

  // R2
  none_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_en == '0) |=> !sel_valid);

  // R4
  spin_demote_chk: assert property (@(posedge clk) disable iff (rst)
    ((fetch_en & ~spin_wait) != '0) |=> (sel_valid && !spin_prev[sel_tid]));

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R8
    flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
      flush[i] |=> (cnt_flat[i*CNT_W +: CNT_W] == '0));

    // R7
    sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
      ((cnt_flat[i*CNT_W +: CNT_W] == {CNT_W{1'b1}}) && !flush[i] &&
       (enter_cnt[i*DW +: DW] >= leave_cnt[i*DW +: DW]))
      |=> (cnt_flat[i*CNT_W +: CNT_W] == {CNT_W{1'b1}}));
  end
endmodule

bind icount_fetch_sel icount_fetch_sel_chk #(
  .N(NUM_THREADS), .CNT_W(CNT_W), .DW(DW), .TW($clog2(NUM_THREADS))
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .fetch_en  (fetch_en),
  .spin_wait (spin_wait),
  .flush     (flush),
  .enter_cnt (enter_cnt),
  .leave_cnt (leave_cnt),
  .sel_valid (sel_valid),
  .sel_tid   (sel_tid),
  .cnt_flat  (cnt_flat)
);

// File: tb/tb_icount_fetch_sel.sv
module tb_icount_fetch_sel;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  fetch_en = '0;
  logic [3:0]  spin_wait = '0;
  logic [3:0]  flush = '0;
  logic [11:0] enter_cnt = '0;
  logic [11:0] leave_cnt = '0;
  logic        sel_valid;
  logic [1:0]  sel_tid;

  always #2 clk = ~clk;

  icount_fetch_sel dut (
    .clk(clk), .rst(rst), .fetch_en(fetch_en), .spin_wait(spin_wait),
    .flush(flush), .enter_cnt(enter_cnt), .leave_cnt(leave_cnt),
    .sel_valid(sel_valid), .sel_tid(sel_tid)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 0;
  int    mcnt [4];
  int    mlast = 3;
  bit    qv   [$];
  int    qt   [$];
  string qtag [$];

  function automatic [11:0] pk(int a, int b, int c, int d);
    return {d[2:0], c[2:0], b[2:0], a[2:0]};
  endfunction

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus and push the expected grant
  task automatic step(input [3:0] en, input [3:0] sp, input [3:0] fl,
                      input [11:0] ent, input [11:0] lv, input string tag);
    bit any_act;
    bit got;
    int bt;
    int bc;
    @(negedge clk);
    fetch_en = en; spin_wait = sp; flush = fl; enter_cnt = ent; leave_cnt = lv;
    any_act = 0;
    for (int t = 0; t < 4; t++) if (en[t] && !sp[t]) any_act = 1;
    got = 0; bt = 0; bc = 0;
    for (int k = 1; k <= 4; k++) begin
      int t;
      t = (mlast + k) % 4;
      if (en[t] && (sp[t] != any_act)) begin
        if (!got || mcnt[t] < bc) begin
          got = 1; bt = t; bc = mcnt[t];
        end
      end
    end
    qv.push_back(got); qt.push_back(got ? bt : 0); qtag.push_back(tag);
    if (got) mlast = bt;
    for (int t = 0; t < 4; t++) begin
      int v;
      v = mcnt[t] + int'(ent[t*3 +: 3]) - int'(lv[t*3 +: 3]);
      if (v < 0) v = 0;
      if (v > 63) v = 63;
      if (fl[t]) v = 0;
      mcnt[t] = v;
    end
  endtask

  // monitor: compare registered outputs shortly after each edge
  always @(posedge clk) begin
    #1;
    if (qv.size() > 0) begin
      bit    ev;
      int    et;
      string tg;
      ev = qv.pop_front(); et = qt.pop_front(); tg = qtag.pop_front();
      check({tg, " valid"}, int'(sel_valid), int'(ev));
      check({tg, " tid"},   int'(sel_tid),   et);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int t = 0; t < 4; t++) mcnt[t] = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 reset valid", int'(sel_valid), 0);
    check("R1 reset tid", int'(sel_tid), 0);
    @(negedge clk); rst = 1'b0;

    // R5 rotation with all counts equal (R1 counts start at zero)
    for (int i = 0; i < 5; i++) step(4'hF, 4'h0, 4'h0, '0, '0, "R5");
    // R6 distinct increments, then R3 lowest count wins, R9 registered timing
    step(4'hF, 4'h0, 4'h0, pk(4, 3, 2, 1), '0, "R6");
    step(4'hF, 4'h0, 4'h0, '0, '0, "R3");
    step(4'hF, 4'h0, 4'h0, '0, pk(0, 0, 2, 0), "R6");
    step(4'hF, 4'h0, 4'h0, '0, '0, "R9");
    step(4'hF, 4'h0, 4'h0, '0, '0, "R3");
    // R4 spinning lowest thread is passed over; all spinning picks min
    step(4'hF, 4'h6, 4'h0, '0, '0, "R4");
    step(4'hF, 4'hF, 4'h0, '0, '0, "R4");
    step(4'h3, 4'h1, 4'h0, '0, '0, "R4");
    // R2 disabled threads and empty eligibility
    step(4'h8, 4'h0, 4'h0, '0, '0, "R2");
    step(4'h0, 4'h0, 4'h0, '0, '0, "R2");
    step(4'h0, 4'hF, 4'h0, '0, '0, "R2");
    // R8 clear everything
    step(4'hF, 4'h0, 4'hF, '0, '0, "R8");
    // R7 ceiling: t0 saturates, t1 reaches 62
    for (int i = 0; i < 20; i++) step(4'h3, 4'h0, 4'h0, pk(4, 0, 0, 0), '0, "R7");
    for (int i = 0; i < 15; i++) step(4'h3, 4'h0, 4'h0, pk(0, 4, 0, 0), '0, "R7");
    step(4'h3, 4'h0, 4'h0, pk(0, 2, 0, 0), '0, "R7");
    step(4'h3, 4'h0, 4'h0, '0, '0, "R7");
    step(4'h3, 4'h0, 4'h0, '0, '0, "R7");
    // R7 floor: t2 stays at 0 under surplus leave, t3 at 1
    step(4'hC, 4'h0, 4'h0, pk(0, 0, 0, 1), pk(0, 0, 4, 0), "R7");
    step(4'hC, 4'h0, 4'h0, '0, '0, "R7");
    step(4'hC, 4'h0, 4'h0, '0, '0, "R7");
    // R8 flush of saturated t0 while entering
    step(4'h3, 4'h0, 4'h1, pk(4, 0, 0, 0), '0, "R8");
    step(4'h3, 4'h0, 4'h0, '0, '0, "R8");
    step(4'h3, 4'h0, 4'h0, '0, '0, "R8");
    // mixed pseudo-random traffic
    for (int i = 0; i < 400; i++) begin
      logic [3:0] en, sp, fl;
      en = 4'($urandom_range(0, 15)) | 4'($urandom_range(0, 1));
      sp = 4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15));
      fl = ($urandom_range(0, 15) == 0) ? 4'($urandom_range(0, 15)) : 4'h0;
      step(en, sp, fl,
           pk($urandom_range(0, 4), $urandom_range(0, 4), $urandom_range(0, 4), $urandom_range(0, 4)),
           pk($urandom_range(0, 4), $urandom_range(0, 4), $urandom_range(0, 4), $urandom_range(0, 4)),
           "R3");
    end
    @(negedge clk);
    fetch_en = '0; enter_cnt = '0; leave_cnt = '0; flush = '0;
    repeat (3) @(posedge clk);
    #2;
    finish_run();
  end
endmodule